// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This core keeps a running wall-clock calendar in packed BCD. An input pulse advances an internal tick prescaler, and every `TICKS_PER_SEC`-th pulse moves the seconds forward. Carries into minutes, hours, weekday, date, month, year and century all settle in the cycle of that advance. With `TICKS_PER_SEC` set to 1, the input is a plain one-pulse-per-second strobe.

A host reaches seven byte-wide registers through a write strobe and a combinational read port. A write loads one register on the next clock edge. Any write cycle swallows a coincident tick, so a value that has just been loaded is never advanced in the same cycle. A write to the seconds register also restarts the prescaler. The hour byte selects between a 24-hour count and a 12-hour count with a PM flag. The month byte carries a century flag that flips each time the year wraps.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, date 0x01, month byte 0x01 (century flag clear) and year 0x00.
- R2: The read port returns seconds at address 0, minutes at 1, hours at 2, weekday at 3, date at 4, month at 5 and year at 6. Bits that are not stored read as 0, and address 7 reads 0x00.
- R3: A write of `wr_data` to `wr_addr` is visible on the read port after the next clock edge. Seconds and minutes keep bits 6:0, hours keep bits 6:0, weekday keeps bits 2:0, date keeps bits 5:0, the month byte keeps bit 7 and bits 4:0, and the year keeps all 8 bits.
- R4: Seconds advance once for every `TICKS_PER_SEC` tick pulses taken. A write to address 0 restarts that count from zero.
- R5: Seconds and minutes count in BCD from 00 to 59 and wrap to 00. The wrap of the seconds carries into minutes, and the wrap of the minutes carries into hours.
- R6: When hour bit 6 is 0 (24-hour mode), hours count 00 to 23. The step after 23 gives 00 and advances the day.
- R7: When hour bit 6 is 1 (12-hour mode), bits 4:0 hold the hour 01 to 12 and bit 5 is PM. The step 11→12 toggles PM and 12→01 leaves it unchanged. The day advances only on the step from 11 PM to 12 AM.
- R8: Each day advance steps the weekday (address 3) from 7 to 1 and otherwise adds 1.
- R9: On a day advance, a date at or past the month length returns to 01 and the month advances. Otherwise the date adds 1. Months 04, 06, 09 and 11 have 30 days and February has 28 days. February has 29 days when the year's value is a multiple of 4. All other months have 31 days.
- R10: A month advance from 12 gives 01 and advances the year. A year advance from 99 gives 00 and toggles the century flag (month byte bit 7).
- R11: A tick that arrives in a cycle with `wr_en` high is discarded. It neither advances the prescaler nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle prescaler pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register written |
| wr_data | input | DATA_W | Write value |
| rd_addr | input | ADDR_W | Register read |
| rd_data | output | DATA_W | Combinational read value |

## Verification
The bound checker watches several rules on every cycle. It checks that a seconds step from 59 gives 00, and that the registers hold still when there is neither a step nor a write. It also checks that a written minute value lands on the next edge, that a write cycle never produces a step, that a step needs a tick, and that the century flag flips as the year leaves 99. Other behaviour depends on particular calendar states, and only the bench scenarios reach those states. This covers 12-hour PM handling, February in leap and common years, 30-day months, the weekday wrap and the restart of the prescaler. The behavioural model catches those by comparing every register on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NUM_REGS = 7;

   // one BCD digit-pair increment, no range limit
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // last date of a month, in BCD
   function automatic logic [7:0] month_days(input logic [4:0] mon, input logic [7:0] yr);
      logic [7:0] ybin;
      ybin = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
      case (mon)
         5'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS_PER_SEC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   input  logic clear,
   output logic sec_step
);
   localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take     = tick && !hold;
   assign sec_step = take && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (take)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic [2:0] wr_hit,
   input  logic [6:0] wr_data,
   output logic [6:0] sec_q,
   output logic [6:0] min_q,
   output logic [6:0] hour_q,
   output logic       day_step
);
   logic       sec_wrap, min_wrap, hour_roll, hour_carry;
   logic [7:0] sec_inc, min_inc, h12_inc, h24_inc;
   logic [6:0] hour_nx;

   assign sec_wrap  = (sec_q == 7'h59);
   assign min_wrap  = (min_q == 7'h59);
   assign hour_roll = step && sec_wrap && min_wrap;
   assign day_step  = hour_roll && hour_carry;
   assign sec_inc   = bcd_inc({1'b0, sec_q});
   assign min_inc   = bcd_inc({1'b0, min_q});
   assign h12_inc   = bcd_inc({3'b0, hour_q[4:0]});
   assign h24_inc   = bcd_inc({2'b0, hour_q[5:0]});

   always_comb begin
      hour_carry = 1'b0;
      if (hour_q[6]) begin
         if (hour_q[4:0] == 5'h11) begin
            hour_nx    = {1'b1, ~hour_q[5], 5'h12};
            hour_carry = hour_q[5];
         end else if (hour_q[4:0] == 5'h12) begin
            hour_nx = {1'b1, hour_q[5], 5'h01};
         end else begin
            hour_nx = {1'b1, hour_q[5], h12_inc[4:0]};
         end
      end else if (hour_q[5:0] == 6'h23) begin
         hour_nx    = 7'h00;
         hour_carry = 1'b1;
      end else begin
         hour_nx = {1'b0, h24_inc[5:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= 7'h00;
         min_q  <= 7'h00;
         hour_q <= 7'h00;
      end else begin
         if (wr_hit[0])                 sec_q  <= wr_data;
         else if (step)                 sec_q  <= sec_wrap ? 7'h00 : sec_inc[6:0];
         if (wr_hit[1])                 min_q  <= wr_data;
         else if (step && sec_wrap)     min_q  <= min_wrap ? 7'h00 : min_inc[6:0];
         if (wr_hit[2])                 hour_q <= wr_data;
         else if (hour_roll)            hour_q <= hour_nx;
      end
   end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       day_step,
   input  logic [3:0] wr_hit,
   input  logic [7:0] wr_data,
   output logic [2:0] dow_q,
   output logic [5:0] date_q,
   output logic [4:0] month_q,
   output logic       cent_q,
   output logic [7:0] year_q
);
   logic [7:0] mdays, date_inc, mon_inc, year_inc;
   logic       date_end, mon_step, year_step;

   assign mdays     = month_days(month_q, year_q);
   assign date_end  = ({2'b0, date_q} >= mdays);
   assign mon_step  = day_step && date_end;
   assign year_step = mon_step && (month_q == 5'h12);
   assign date_inc  = bcd_inc({2'b0, date_q});
   assign mon_inc   = bcd_inc({3'b0, month_q});
   assign year_inc  = bcd_inc(year_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dow_q   <= 3'd1;
         date_q  <= 6'h01;
         month_q <= 5'h01;
         cent_q  <= 1'b0;
         year_q  <= 8'h00;
      end else begin
         if (wr_hit[0])      dow_q  <= wr_data[2:0];
         else if (day_step)  dow_q  <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
         if (wr_hit[1])      date_q <= wr_data[5:0];
         else if (day_step)  date_q <= date_end ? 6'h01 : date_inc[5:0];
         if (wr_hit[2]) begin
            month_q <= wr_data[4:0];
            cent_q  <= wr_data[7];
         end else if (mon_step) begin
            month_q <= (month_q == 5'h12) ? 5'h01 : mon_inc[4:0];
         end
         if (wr_hit[3])      year_q <= wr_data;
         else if (year_step) begin
            year_q <= (year_q == 8'h99) ? 8'h00 : year_inc;
            if (year_q == 8'h99) cent_q <= ~cent_q;
         end
      end
   end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 4,
   parameter int ADDR_W        = 3,
   parameter int DATA_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("bcd_rtc_core: DATA_W must be 8");
      end
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("bcd_rtc_core: ADDR_W must cover seven registers");
      end
      if (TICKS_PER_SEC < 1) begin : g_bad_tps
         $error("bcd_rtc_core: TICKS_PER_SEC must be at least 1");
      end
   endgenerate

   logic [NUM_REGS-1:0] wr_hit;
   logic       sec_step, day_step, cent_q;
   logic [6:0] sec_q, min_q, hour_q;
   logic [2:0] dow_q;
   logic [5:0] date_q;
   logic [4:0] month_q;
   logic [7:0] year_q;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
   end

   rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hold(wr_en),
      .clear(wr_hit[0]), .sec_step(sec_step)
   );

   rtc_clock_chain u_clock (
      .clk(clk), .rst_n(rst_n), .step(sec_step), .wr_hit(wr_hit[2:0]),
      .wr_data(wr_data[6:0]), .sec_q(sec_q), .min_q(min_q),
      .hour_q(hour_q), .day_step(day_step)
   );

   rtc_date_chain u_date (
      .clk(clk), .rst_n(rst_n), .day_step(day_step), .wr_hit(wr_hit[6:3]),
      .wr_data(wr_data[7:0]), .dow_q(dow_q), .date_q(date_q),
      .month_q(month_q), .cent_q(cent_q), .year_q(year_q)
   );

   always_comb begin
      case (rd_addr)
         ADDR_W'(0): rd_data = {1'b0, sec_q};
         ADDR_W'(1): rd_data = {1'b0, min_q};
         ADDR_W'(2): rd_data = {1'b0, hour_q};
         ADDR_W'(3): rd_data = {5'b0, dow_q};
         ADDR_W'(4): rd_data = {2'b0, date_q};
         ADDR_W'(5): rd_data = {cent_q, 2'b0, month_q};
         ADDR_W'(6): rd_data = year_q;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [6:0]        wr_data,
   input logic              sec_step,
   input logic [6:0]        sec_q,
   input logic [6:0]        min_q,
   input logic [7:0]        year_q,
   input logic              cent_q
);
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_step && sec_q == 7'h59) |=> (sec_q == 7'h00)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !sec_step) |=> ($stable(sec_q) && $stable(min_q) && $stable(year_q) && $stable(cent_q))); // R4

   AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !sec_step); // R4

   AST_MIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(1)) |=> (min_q == $past(wr_data))); // R3

   AST_WRITE_EATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !sec_step); // R11

   AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && year_q == 8'h99) |=> ((year_q == 8'h99) || (cent_q != $past(cent_q)))); // R10
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data[6:0]), .sec_step(sec_step), .sec_q(sec_q), .min_q(min_q),
   .year_q(year_q), .cent_q(cent_q)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
   localparam int CLK_PERIOD = 20;
   localparam int TPS        = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;

   int total = 0;
   int bad   = 0;
   string cur_tag = "R1";

   // behavioural reference state, binary integers
   int m_sec = 0, m_min = 0, m_h = 0, m_pm = 0, m_12 = 0;
   int m_dow = 1, m_date = 1, m_mon = 1, m_yr = 0, m_cent = 0, m_cnt = 0;

   bcd_rtc_core #(.TICKS_PER_SEC(TPS)) u_bcd_rtc_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mlen(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] model_byte(input int a);
      case (a)
         0: return i2b(m_sec);
         1: return i2b(m_min);
         2: return m_12 ? (8'h40 | 8'(m_pm << 5) | i2b(m_h)) : i2b(m_h);
         3: return 8'(m_dow);
         4: return i2b(m_date);
         5: return 8'(m_cent << 7) | i2b(m_mon);
         6: return i2b(m_yr);
         default: return 8'h00;
      endcase
   endfunction

   task m_day;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      if (m_date >= mlen(m_mon, m_yr)) begin
         m_date = 1;
         if (m_mon == 12) begin
            m_mon = 1;
            if (m_yr == 99) begin m_yr = 0; m_cent ^= 1; end
            else m_yr++;
         end else m_mon++;
      end else m_date++;
   endtask

   task m_second;
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0;
            if (m_12 != 0) begin
               if (m_h == 11) begin
                  m_h = 12;
                  if (m_pm != 0) begin m_pm = 0; m_day(); end
                  else m_pm = 1;
               end else if (m_h == 12) m_h = 1;
               else m_h++;
            end else begin
               m_h++;
               if (m_h == 24) begin m_h = 0; m_day(); end
            end
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_h = 0; m_pm = 0; m_12 = 0;
         m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_cent = 0; m_cnt = 0;
      end else if (wr_en) begin
         case (wr_addr)
            3'd0: begin m_sec = b2i({1'b0, wr_data[6:0]}); m_cnt = 0; end
            3'd1: m_min = b2i({1'b0, wr_data[6:0]});
            3'd2: begin
               m_12 = int'(wr_data[6]);
               if (m_12 != 0) begin m_pm = int'(wr_data[5]); m_h = b2i({3'b0, wr_data[4:0]}); end
               else begin m_pm = 0; m_h = b2i({2'b0, wr_data[5:0]}); end
            end
            3'd3: m_dow = int'(wr_data[2:0]);
            3'd4: m_date = b2i({2'b0, wr_data[5:0]});
            3'd5: begin m_cent = int'(wr_data[7]); m_mon = b2i({3'b0, wr_data[4:0]}); end
            3'd6: m_yr = b2i(wr_data);
            default: ;
         endcase
      end else if (tick) begin
         if (m_cnt == TPS - 1) begin m_cnt = 0; m_second(); end
         else m_cnt++;
      end
   end

   task check_all;
      for (int i = 0; i < 7; i++) begin
         logic [7:0] exp;
         rd_addr = 3'(i);
         #1;
         exp = model_byte(i);
         total++;
         if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr %0d actual %h expected %h", cur_tag, i, rd_data, exp);
         end
      end
   endtask

   task cyc(input logic t, input logic we, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      check_all();
      tick = t; wr_en = we; wr_addr = a; wr_data = d;
   endtask

   task wr(input logic [2:0] a, input logic [7:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task secs(input int n);
      for (int i = 0; i < n * TPS; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
   endtask

   task set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                input logic [7:0] yr);
      wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw); wr(3'd4, dt);
      wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, s);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_tag = "R1";
      cyc(1'b0, 1'b0, 3'd0, 8'h00);

      cur_tag = "R2";
      set_all(8'h12, 8'h34, 8'h15, 8'h03, 8'h17, 8'h88, 8'h42);
      cyc(1'b0, 1'b0, 3'd0, 8'h00);
      rd_addr = 3'd7; #1; total++;
      if (rd_data !== 8'h00) begin bad++; $display("FAIL R2 addr 7 actual %h expected 00", rd_data); end

      cur_tag = "R3";
      wr(3'd0, 8'hD9); wr(3'd3, 8'hFE); wr(3'd4, 8'hD5); wr(3'd5, 8'hE9);
      cyc(1'b0, 1'b0, 3'd0, 8'h00);

      cur_tag = "R4";
      wr(3'd0, 8'h10);
      repeat (3) cyc(1'b1, 1'b0, 3'd0, 8'h00);
      wr(3'd0, 8'h20);
      repeat (3) cyc(1'b1, 1'b0, 3'd0, 8'h00);
      cyc(1'b0, 1'b0, 3'd0, 8'h00);
      cyc(1'b1, 1'b0, 3'd0, 8'h00);
      secs(3);

      cur_tag = "R5";
      set_all(8'h58, 8'h59, 8'h05, 8'h02, 8'h10, 8'h06, 8'h21);
      secs(3);
      set_all(8'h57, 8'h00, 8'h05, 8'h02, 8'h10, 8'h06, 8'h21);
      secs(65);

      cur_tag = "R6";
      set_all(8'h59, 8'h59, 8'h23, 8'h04, 8'h10, 8'h06, 8'h21);
      secs(2);
      set_all(8'h59, 8'h59, 8'h09, 8'h04, 8'h10, 8'h06, 8'h21);
      secs(1);

      cur_tag = "R7";
      set_all(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h06, 8'h21);
      secs(1);
      set_all(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h06, 8'h21);
      secs(1);
      set_all(8'h59, 8'h59, 8'h71, 8'h02, 8'h10, 8'h06, 8'h21);
      secs(2);

      cur_tag = "R8";
      set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h06, 8'h21);
      secs(1);

      cur_tag = "R9";
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h23);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h11, 8'h00);
      secs(1);

      cur_tag = "R10";
      set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h92, 8'h99);
      secs(1);
      set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h49);
      secs(1);

      cur_tag = "R11";
      set_all(8'h30, 8'h02, 8'h08, 8'h05, 8'h11, 8'h03, 8'h22);
      repeat (3) cyc(1'b1, 1'b0, 3'd0, 8'h00);
      cyc(1'b1, 1'b1, 3'd1, 8'h05);
      cyc(1'b0, 1'b0, 3'd0, 8'h00);
      cyc(1'b1, 1'b0, 3'd0, 8'h00);
      cyc(1'b0, 1'b0, 3'd0, 8'h00);
      cyc(1'b0, 1'b0, 3'd0, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule